// File: doc/BRIEF.md
# Statically Scheduled Tile Switch

This block is the communication interface of one tile in a two-dimensional mesh. A crossbar connects four neighbour links (north, south, east, west) and the tile's local core. Routing is not decided by packet headers or arbitration. A sequencer steps a program counter through a local instruction memory, and each instruction word sets every crossbar connection for exactly one clock cycle. The traffic pattern is therefore fixed when the schedule is compiled. One instruction may send a single input to several outputs in the same cycle.

The instruction memory is filled through a write port while the switch is stopped. When `run_en` is high, the program counter starts at entry 0 and runs up to the programmed last index. It then wraps to 0, so the schedule repeats with no end. Link outputs are registered, so a word moves across one tile per clock.

Two 4-entry FIFOs sit between the network and the core, one for each direction. The core side of each FIFO is a valid/ready stream:
- A word passes only in a cycle where both valid and ready are high.
- `core_in_ready` is low while the inbound FIFO holds 4 words.
- `core_out_data` holds its value while `core_out_valid` is high and `core_out_ready` is low.

Mesh links have no back-pressure, because the schedule guarantees slot ownership. Each link carries only a valid flag.

Top module: `tile_switch`

## Requirements
- R1: After reset, all link output valids are 0, `core_out_valid` is 0, `core_in_ready` is 1, both error flags are 0, and every instruction entry is zero (no routes).
- R2: Instruction bits [3k+2:3k] select the source for output k, where k=0 north, 1 south, 2 east, 3 west and 4 core. The codes are: 0 none, 1 north in, 2 south in, 3 east in, 4 west in, 5 core inbound FIFO head. Codes 6 and 7 act as none.
- R3: A link output shows, one clock later, the data and valid of the source selected in the current instruction. An output with no source drives valid 0.
- R4: One source selected by several fields appears on all of those outputs in the same cycle.
- R5: While running, the program counter starts at 0 on the first running cycle and advances by one each cycle. After the cycle that uses entry `sched_len`, it returns to 0.
- R6: A write on the load port takes effect only while `run_en` is low. A write while running is ignored.
- R7: While `run_en` is low, no routes are applied: link output valids are 0 one clock later, and neither FIFO is read or written by the schedule.
- R8: The inbound core FIFO accepts a word when `core_in_valid` and `core_in_ready` are both high. It holds up to 4 words and hands them out in arrival order. It loses one word per cycle in which any field selects the core, however many fields select it.
- R9: If a field selects the core while the inbound FIFO is empty, that output gets an invalid word and the sticky flag `err_empty_read` is set until reset.
- R10: A valid word routed to the core output enters the outbound FIFO, and the core drains it in order through valid/ready. If the FIFO already holds 4 words, the word is dropped and the sticky flag `err_full_write` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Run the schedule; low stops it and allows loading |
| sched_len | input | AW | Index of last schedule entry before wrap |
| imem_we | input | 1 | Instruction write strobe |
| imem_addr | input | AW | Instruction write address |
| imem_wdata | input | 15 | Instruction word |
| link_in_data | input | 4 x DW | Link input data, index 0 N, 1 S, 2 E, 3 W |
| link_in_valid | input | 4 | Link input valid flags |
| link_out_data | output | 4 x DW | Registered link output data |
| link_out_valid | output | 4 | Registered link output valid flags |
| core_in_data | input | DW | Word from the core |
| core_in_valid | input | 1 | Core offers a word |
| core_in_ready | output | 1 | Inbound FIFO can accept |
| core_out_data | output | DW | Word to the core |
| core_out_valid | output | 1 | Outbound FIFO holds a word |
| core_out_ready | input | 1 | Core takes the word |
| err_empty_read | output | 1 | Sticky: schedule read an empty inbound FIFO |
| err_full_write | output | 1 | Sticky: schedule wrote a full outbound FIFO |

## Verification
The bench targets the following corner cases:
- **Multicast from the core.** Two fields select the core in the same cycle. A design that popped once per field would skip words in the inbound stream.
- **Schedule reads an empty inbound FIFO.** A design that skipped the check would forward stale data as valid, or would leave the error flag clear.
- **Core stalls too long.** The core holds `core_out_ready` low while the outbound FIFO fills. A design without the full check would overwrite the oldest word instead of dropping the new one and raising the flag.
- **Sequencer edges.** The bench covers wrap at `sched_len`, restart at 0 after `run_en` returns high, and a load while running. A sequencer that wrapped one entry late, or that let a running write through, would show the wrong route on the link outputs.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  localparam int NLINK  = 4;               // north, south, east, west
  localparam int NOUT   = NLINK + 1;       // plus the core output
  localparam int NSRC   = NLINK + 2;       // none, four links, core
  localparam int SELW   = 3;
  localparam int INSTRW = NOUT * SELW;

  // source-select codes; 6 and 7 fall back to none
  localparam logic [SELW-1:0] SRC_NONE = 3'd0;
  localparam logic [SELW-1:0] SRC_N    = 3'd1;
  localparam logic [SELW-1:0] SRC_S    = 3'd2;
  localparam logic [SELW-1:0] SRC_E    = 3'd3;
  localparam logic [SELW-1:0] SRC_W    = 3'd4;
  localparam logic [SELW-1:0] SRC_CORE = 3'd5;

  // output field slots
  localparam int OUT_CORE = NLINK;
endpackage

// File: rtl/tsw_seq.sv
// Schedule store and program counter. DEPTH must be a power of two.
module tsw_seq
  import tsw_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [AW-1:0]     sched_len,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [INSTRW-1:0] wdata,
  output logic [INSTRW-1:0] instr
);
  logic [INSTRW-1:0] slots [DEPTH];
  logic [AW-1:0]     pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else if (we && !run_en) begin
      slots[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run_en) pc <= '0;
    else if (pc == sched_len) pc <= '0;
    else pc <= pc + AW'(1);
  end

  // stopped switch applies an all-none word
  assign instr = run_en ? slots[pc] : '0;

  assert_pc_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && pc == sched_len) |=> (pc == '0));
  assert_pc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && pc != sched_len) |=> (!run_en || pc == $past(pc) + AW'(1)));
  assert_pc_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (pc == '0));
endmodule

// File: rtl/tsw_fifo.sv
module tsw_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          full,
  output logic          empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] store [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign rdata = store[rp];

  always_ff @(posedge clk) begin
    if (push) store[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  // callers gate push/pop; also guards the outbound side of R10
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/tsw_xbar.sv
// One source multiplexer per output, driven by its own field.
module tsw_xbar
  import tsw_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [INSTRW-1:0]        instr,
  input  logic [NSRC-1:0][DW-1:0]  src_data,
  input  logic [NSRC-1:0]          src_valid,
  output logic [NOUT-1:0][DW-1:0]  sel_data,
  output logic [NOUT-1:0]          sel_valid,
  output logic                     core_read
);
  logic [NOUT-1:0] core_hit;

  for (genvar o = 0; o < NOUT; o++) begin : g_out
    logic [SELW-1:0] fld;
    logic [SELW-1:0] idx;
    assign fld = instr[o*SELW +: SELW];
    assign idx = (fld <= SRC_CORE) ? fld : SRC_NONE;
    assign sel_valid[o] = src_valid[idx];
    assign sel_data[o]  = src_data[idx];
    assign core_hit[o]  = (fld == SRC_CORE);
  end

  assign core_read = |core_hit;
endmodule

// File: rtl/tile_switch.sv
module tile_switch
  import tsw_pkg::*;
#(
  parameter int DW       = 16,
  parameter int DEPTH    = 16,
  parameter int FIFO_DEP = 4,
  parameter int AW       = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run_en,
  input  logic [AW-1:0]           sched_len,
  input  logic                    imem_we,
  input  logic [AW-1:0]           imem_addr,
  input  logic [INSTRW-1:0]       imem_wdata,
  input  logic [NLINK-1:0][DW-1:0] link_in_data,
  input  logic [NLINK-1:0]        link_in_valid,
  output logic [NLINK-1:0][DW-1:0] link_out_data,
  output logic [NLINK-1:0]        link_out_valid,
  input  logic [DW-1:0]           core_in_data,
  input  logic                    core_in_valid,
  output logic                    core_in_ready,
  output logic [DW-1:0]           core_out_data,
  output logic                    core_out_valid,
  input  logic                    core_out_ready,
  output logic                    err_empty_read,
  output logic                    err_full_write
);
  logic [INSTRW-1:0]       instr;
  logic [NSRC-1:0][DW-1:0] src_data;
  logic [NSRC-1:0]         src_valid;
  logic [NOUT-1:0][DW-1:0] sel_data;
  logic [NOUT-1:0]         sel_valid;
  logic                    core_read;
  logic [DW-1:0]           cin_head;
  logic                    cin_full, cin_empty, cout_full, cout_empty;
  logic                    cout_push;

  tsw_seq #(.DEPTH(DEPTH), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .sched_len(sched_len),
    .we(imem_we), .waddr(imem_addr), .wdata(imem_wdata), .instr(instr)
  );

  assign core_in_ready = !cin_full;

  tsw_fifo #(.DW(DW), .DEPTH(FIFO_DEP)) u_cin (
    .clk(clk), .rst_n(rst_n),
    .push(core_in_valid && !cin_full), .wdata(core_in_data),
    .pop(core_read && !cin_empty), .rdata(cin_head),
    .full(cin_full), .empty(cin_empty)
  );

  always_comb begin
    src_data  = '0;
    src_valid = '0;
    for (int i = 0; i < NLINK; i++) begin
      src_data[i+1]  = link_in_data[i];
      src_valid[i+1] = link_in_valid[i];
    end
    src_data[NSRC-1]  = cin_head;
    src_valid[NSRC-1] = !cin_empty;
  end

  tsw_xbar #(.DW(DW)) u_xbar (
    .instr(instr), .src_data(src_data), .src_valid(src_valid),
    .sel_data(sel_data), .sel_valid(sel_valid), .core_read(core_read)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_out_valid <= '0;
      link_out_data  <= '0;
    end else begin
      for (int i = 0; i < NLINK; i++) begin
        link_out_valid[i] <= sel_valid[i];
        if (sel_valid[i]) link_out_data[i] <= sel_data[i];
      end
    end
  end

  assign cout_push      = sel_valid[OUT_CORE] && !cout_full;
  assign core_out_valid = !cout_empty;

  tsw_fifo #(.DW(DW), .DEPTH(FIFO_DEP)) u_cout (
    .clk(clk), .rst_n(rst_n),
    .push(cout_push), .wdata(sel_data[OUT_CORE]),
    .pop(core_out_ready && !cout_empty), .rdata(core_out_data),
    .full(cout_full), .empty(cout_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_empty_read <= 1'b0;
      err_full_write <= 1'b0;
    end else begin
      if (core_read && cin_empty) err_empty_read <= 1'b1;
      if (sel_valid[OUT_CORE] && cout_full) err_full_write <= 1'b1;
    end
  end

  assert_link_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (link_out_valid == '0));
  assert_err_empty_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_empty_read |=> err_empty_read);
  assert_err_full_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_full_write |=> err_full_write);
  assert_core_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (core_out_valid && !core_out_ready) |=> (core_out_valid && $stable(core_out_data)));
endmodule

// File: tb/tile_switch_bench.sv
module tile_switch_bench;
  localparam int DW = 16, DEPTH = 16, AW = 4, IW = 15;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, run_en, imem_we, core_in_valid, core_in_ready;
  logic core_out_valid, core_out_ready, err_empty_read, err_full_write;
  logic [AW-1:0] sched_len, imem_addr;
  logic [IW-1:0] imem_wdata;
  logic [3:0][DW-1:0] link_in_data, link_out_data;
  logic [3:0] link_in_valid, link_out_valid;
  logic [DW-1:0] core_in_data, core_out_data;

  tile_switch u_tile_switch (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .sched_len(sched_len),
    .imem_we(imem_we), .imem_addr(imem_addr), .imem_wdata(imem_wdata),
    .link_in_data(link_in_data), .link_in_valid(link_in_valid),
    .link_out_data(link_out_data), .link_out_valid(link_out_valid),
    .core_in_data(core_in_data), .core_in_valid(core_in_valid),
    .core_in_ready(core_in_ready), .core_out_data(core_out_data),
    .core_out_valid(core_out_valid), .core_out_ready(core_out_ready),
    .err_empty_read(err_empty_read), .err_full_write(err_full_write)
  );

  int checks = 0, failures = 0;
  string tag = "R1";
  logic [IW-1:0] m_mem [DEPTH];
  int m_pc = 0;
  logic [DW-1:0] cin_q[$], cout_q[$];
  bit m_eempty = 0, m_efull = 0;
  logic [3:0] e_lv;
  logic [DW-1:0] e_ld [4];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [IW-1:0] word(int n, int s, int e, int w, int c);
    return {3'(c), 3'(w), 3'(e), 3'(s), 3'(n)};
  endfunction

  // one clock: predict, advance, compare
  task automatic tick();
    bit run = run_en;
    logic [IW-1:0] ins = run ? m_mem[m_pc] : '0;
    bit cin_emp = (cin_q.size() == 0);
    logic [DW-1:0] head = cin_emp ? '0 : cin_q[0];
    bit cin_full_pre = (cin_q.size() >= 4);
    bit cout_full_pre = (cout_q.size() >= 4);
    bit core_rd = 0, push_p = 0;
    logic [DW-1:0] pd = '0;
    for (int k = 0; k < 5; k++) begin
      int f = int'(ins[3*k +: 3]);
      bit v = 0;
      logic [DW-1:0] d = '0;
      if (f >= 1 && f <= 4) begin
        v = link_in_valid[f-1];
        d = link_in_data[f-1];
      end else if (f == 5) begin
        core_rd = 1;
        v = !cin_emp;
        d = head;
      end
      if (k < 4) begin
        e_lv[k] = v;
        e_ld[k] = d;
      end else if (v) begin
        if (!cout_full_pre) begin push_p = 1; pd = d; end
        else m_efull = 1;
      end
    end
    if (core_rd && cin_emp) m_eempty = 1;
    if (core_out_ready && cout_q.size() > 0) void'(cout_q.pop_front());
    if (push_p) cout_q.push_back(pd);
    if (core_rd && !cin_emp) void'(cin_q.pop_front());
    if (core_in_valid && !cin_full_pre) cin_q.push_back(core_in_data);
    if (!run && imem_we) m_mem[imem_addr] = imem_wdata;
    if (!run) m_pc = 0;
    else if (m_pc == int'(sched_len)) m_pc = 0;
    else m_pc = (m_pc + 1) % DEPTH;
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      chk(tag, "link valid", 32'(link_out_valid[k]), 32'(e_lv[k]));
      if (e_lv[k]) chk(tag, "link data", 32'(link_out_data[k]), 32'(e_ld[k]));
    end
    chk("R8", "core_in_ready", 32'(core_in_ready), 32'(cin_q.size() < 4));
    chk("R10", "core_out_valid", 32'(core_out_valid), 32'(cout_q.size() > 0));
    if (cout_q.size() > 0) chk("R10", "core_out_data", 32'(core_out_data), 32'(cout_q[0]));
    chk("R9", "err_empty_read", 32'(err_empty_read), 32'(m_eempty));
    chk("R10", "err_full_write", 32'(err_full_write), 32'(m_efull));
  endtask

  task automatic load(int a, logic [IW-1:0] w);
    imem_we = 1; imem_addr = AW'(a); imem_wdata = w;
    tick();
    imem_we = 0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    rst_n = 0; run_en = 0; imem_we = 0; imem_addr = '0; imem_wdata = '0;
    sched_len = '0; link_in_data = '0; link_in_valid = '0;
    core_in_data = '0; core_in_valid = 0; core_out_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1", "reset link valid", 32'(link_out_valid), 0);
    chk("R1", "reset core_in_ready", 32'(core_in_ready), 1);
    chk("R1", "reset core_out_valid", 32'(core_out_valid), 0);
    chk("R1", "reset errors", 32'({err_empty_read, err_full_write}), 0);
    run_en = 1; link_in_valid = 4'hF; link_in_data = {4{16'h5A5A}};
    tick();   // all-zero schedule after reset: nothing routed (R1)
    run_en = 0; link_in_valid = '0;
    tick();

    // R9: schedule reads empty inbound FIFO
    tag = "R9";
    load(0, word(5, 0, 0, 0, 0));
    run_en = 1;
    tick();
    chk("R9", "empty read output invalid", 32'(link_out_valid[0]), 0);
    chk("R9", "empty read flag", 32'(err_empty_read), 1);
    run_en = 0; tick();

    // R4: multicast north to south and east
    tag = "R4";
    load(0, word(0, 1, 1, 0, 0));
    run_en = 1; link_in_valid = 4'b0001; link_in_data[0] = 16'hABCD;
    tick();
    chk("R4", "south copy", 32'(link_out_data[1]), 32'h ABCD);
    chk("R4", "east copy", 32'(link_out_data[2]), 32'h ABCD);
    chk("R4", "north not routed", 32'(link_out_valid[0]), 0);
    run_en = 0; link_in_valid = '0; tick();

    // R5: entry i routes north to output i, wrap after entry 2
    tag = "R5";
    load(0, word(1, 0, 0, 0, 0));
    load(1, word(0, 1, 0, 0, 0));
    load(2, word(0, 0, 1, 0, 0));
    sched_len = AW'(2); run_en = 1; link_in_valid = 4'b0001;
    for (int c = 0; c < 7; c++) begin
      link_in_data[0] = DW'(16'h100 + c);
      tick();
      chk("R5", "wrap position", 32'(link_out_valid), 32'(1 << (c % 3)));
    end
    // R6: writes while running are ignored
    tag = "R6";
    imem_we = 1; imem_addr = AW'(1); imem_wdata = '0;
    repeat (3) tick();
    imem_we = 0;
    repeat (6) tick();
    // R7: stopped switch applies nothing
    tag = "R7";
    run_en = 0;
    for (int c = 0; c < 6; c++) begin
      link_in_valid = 4'($urandom); link_in_data = 64'({$urandom, $urandom});
      tick();
    end
    tag = "R5";
    run_en = 1; link_in_valid = 4'b0001;
    tick();
    chk("R5", "restart at entry 0", 32'(link_out_valid), 1);
    run_en = 0; link_in_valid = '0; tick();

    // R8: core multicast pops once
    tag = "R8";
    load(0, word(0, 5, 5, 0, 0));
    sched_len = '0; core_in_valid = 1;
    for (int c = 0; c < 5; c++) begin
      core_in_data = DW'(16'hC00 + c);
      tick();
    end
    chk("R8", "ready low when 4 held", 32'(core_in_ready), 0);
    core_in_valid = 0; run_en = 1;
    for (int c = 0; c < 4; c++) begin
      tick();
      chk("R8", "in-order pop south", 32'(link_out_data[1]), 32'(16'hC00 + c));
    end
    run_en = 0; tick();

    // R10: core stalls, outbound FIFO fills, then drains
    tag = "R10";
    load(0, word(0, 0, 0, 0, 1));
    run_en = 1; link_in_valid = 4'b0001; core_out_ready = 0;
    for (int c = 0; c < 6; c++) begin
      link_in_data[0] = DW'(16'hD00 + c);
      tick();
    end
    chk("R10", "overflow flag", 32'(err_full_write), 1);
    chk("R10", "oldest kept", 32'(core_out_data), 32'h D00);
    link_in_valid = '0; core_out_ready = 1;
    repeat (5) tick();
    run_en = 0; tick();

    // random schedules and traffic
    tag = "R2/R3";
    for (int a = 0; a < DEPTH; a++) load(a, IW'($urandom));
    sched_len = AW'($urandom);
    run_en = 1;
    for (int c = 0; c < 3000; c++) begin
      link_in_valid = 4'($urandom); link_in_data = 64'({$urandom, $urandom});
      core_in_valid = 1'($urandom); core_in_data = DW'($urandom);
      core_out_ready = ($urandom % 4) != 0;
      if ($urandom % 64 == 0) run_en = ~run_en;
      tick();
    end
    finish_run();
  end
endmodule